// File: doc/BRIEF.md
# Frame-Sync Aligned Clock Divider Bank

This block holds a set of programmable clock dividers. All of them run from one locked, high-rate system clock, and each one makes a slow output clock whose period is a programmable number of system-clock cycles. A slow external sync signal, carrying frame or multiframe timing, can pull the outputs back into phase. Each falling edge of that sync signal places the falling edge of every eligible output at the same instant.

The sync input is brought into the system-clock domain through two flops. Only its falling edge counts. Each output carries a small frequency class code. A sync-rate selector says whether the sync belongs to the slow 2 kHz class or to the 4/8 kHz class. Whether an output may be realigned follows from its class code and that selector. Realignment is also gated by three inputs, and all three must be high: a lock indication from the main loop, an alignment enable and a sync qualification. An error flag goes high when a conflicting phase build-out option is switched on while alignment is enabled.

Top module: `fsync_divbank`

## Requirements
- R1: While reset is held, and at the first clock edge after it is released, every `clk_out` bit is low and `cfg_err` is low.
- R2: With no realignment, each divider with ratio N (a ratio of 0 or 1 is treated as 2) has a period of N clock cycles. Within each period it is high for N - floor(N/2) cycles and then low for floor(N/2) cycles. After reset the first high phase starts at the first edge after release.
- R3: `sync_in` is sampled on every rising clock edge. When it is first sampled low at edge k, after being sampled high at edge k-1, an eligible and permitted output is low from edge k+2. Its low phase then lasts floor(N/2) cycles, and free running resumes after that.
- R4: Only the high-to-low transition of the sampled sync has an effect. A rising transition, or a level held steady, never changes the phase of any divider.
- R5: `freq_cls` holds 2 bits per output: 0 means below 2 kHz, 1 means from 2 kHz up to but not including 8 kHz, and 2 or 3 means 8 kHz and above. With `sync_rate_8k`=0 (2 kHz sync), classes 1, 2 and 3 are realigned. With `sync_rate_8k`=1 (4 or 8 kHz sync), only classes 2 and 3 are realigned.
- R6: A realignment at edge k+2 happens only if `pll_locked`, `align_en` and `sync_qual` are all high as sampled at edge k+2. Otherwise every divider keeps running freely.
- R7: `cfg_err` is high one cycle after `pbo_en` and `align_en` are both sampled high. It is low one cycle after either of them is sampled low.
- R8: The divide ratio and class of output i sit at bits [16*i+15:16*i] of `div_ratio` and bits [2*i+1:2*i] of `freq_cls`, and each output's behaviour depends only on its own fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Locked system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | External frame/multiframe sync (asynchronous) |
| sync_rate_8k | input | 1 | 0: 2 kHz sync class, 1: 4/8 kHz sync class |
| pll_locked | input | 1 | Main loop lock indication |
| align_en | input | 1 | External sync alignment enable |
| sync_qual | input | 1 | Sync qualified indication |
| pbo_en | input | 1 | Phase build-out option enable (must be off with alignment) |
| div_ratio | input | NUM_OUT*DIV_W | Per-output divide ratios, output i at slice i |
| freq_cls | input | 2*NUM_OUT | Per-output frequency class codes |
| clk_out | output | NUM_OUT | Divided output clocks |
| cfg_err | output | 1 | Phase build-out enabled together with alignment |

## Verification
The assertions take for granted that `sync_in` has already passed through the two-flop stage. They also take for granted that the gating inputs and class codes are steady at each system-clock edge. The bench therefore changes every input only at the falling clock edge and holds each sync level for several cycles, so no sync pulse is narrower than the two-flop stage can resolve. Ratios and classes are changed only between sync events. The gating inputs are dropped one at a time across separate sync falls.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  // A ratio below two cannot toggle, so it is treated as two.
  function automatic logic [31:0] eff_ratio(input logic [31:0] r);
    return (r < 32'd2) ? 32'd2 : r;
  endfunction

  // Cycles spent high within one period: ceil(n/2).
  function automatic logic [31:0] high_len(input logic [31:0] n);
    return n - (n >> 1);
  endfunction

  // Class 0 (<2k) never aligns, class 1 only on a 2 kHz sync, class 2/3 always.
  function automatic logic class_ok(input logic [1:0] cls, input logic rate8);
    return rate8 ? cls[1] : (cls != 2'b00);
  endfunction

endpackage

// File: rtl/fsd_sync_edge.sv
module fsd_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic fall_evt
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= sync_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fall_evt = s3 & ~s2;

  // R3: an event means the raw input was high three edges back and low two edges back
  assert_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |-> ($past(sync_in, 2) == 1'b0 && $past(sync_in, 3) == 1'b1));

endmodule

// File: rtl/fsd_divider.sv
module fsd_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio,
  input  logic             realign,
  output logic             clk_out
);
  import fsd_pkg::*;

  logic [DIV_W-1:0] cnt, cnt_nxt, n_eff, h_len;

  always_comb begin
    n_eff = DIV_W'(eff_ratio(32'(ratio)));
    h_len = DIV_W'(high_len(32'(n_eff)));
    if (realign)
      cnt_nxt = h_len;
    else if (cnt >= n_eff - DIV_W'(1))
      cnt_nxt = '0;
    else
      cnt_nxt = cnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '1;
      clk_out <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      clk_out <= (cnt_nxt < h_len);
    end
  end

  // R3: a realignment drives the output low on the following edge
  assert_fall_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !clk_out);

  // R2: without realignment the phase only advances by one or wraps to zero
  assert_free_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !realign |=> (cnt == '0 || cnt == $past(cnt) + DIV_W'(1)));

endmodule

// File: rtl/fsync_divbank.sv
module fsync_divbank #(
  parameter int NUM_OUT = 4,
  parameter int DIV_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_in,
  input  logic                     sync_rate_8k,
  input  logic                     pll_locked,
  input  logic                     align_en,
  input  logic                     sync_qual,
  input  logic                     pbo_en,
  input  logic [NUM_OUT*DIV_W-1:0] div_ratio,
  input  logic [2*NUM_OUT-1:0]     freq_cls,
  output logic [NUM_OUT-1:0]       clk_out,
  output logic                     cfg_err
);
  import fsd_pkg::*;

  logic               fall_evt;
  logic               align_evt;
  logic [NUM_OUT-1:0] realign;

  fsd_sync_edge u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  (sync_in),
    .fall_evt (fall_evt)
  );

  assign align_evt = fall_evt & pll_locked & align_en & sync_qual;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
    assign realign[g] = align_evt & class_ok(freq_cls[2*g +: 2], sync_rate_8k);

    fsd_divider #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .ratio   (div_ratio[g*DIV_W +: DIV_W]),
      .realign (realign[g]),
      .clk_out (clk_out[g])
    );

    // R5: only outputs whose class meets the sync-rate threshold are realigned
    assert_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
      realign[g] |-> (freq_cls[2*g +: 2] >= (sync_rate_8k ? 2'd2 : 2'd1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= pbo_en & align_en;
  end

  // R6: realignment requires lock, enable and qualification together
  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|realign) |-> (pll_locked && align_en && sync_qual));

  // R4: realignment only ever follows a detected falling edge
  assert_edge_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|realign) |-> fall_evt);

  // R7: conflicting options raise the flag one cycle later
  assert_cfg_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pbo_en && align_en) |=> cfg_err);

  // R7: the flag drops one cycle after the conflict ends
  assert_cfg_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pbo_en && align_en) |=> !cfg_err);

endmodule

// File: tb/tb_fsync_divbank.sv
`timescale 1ns/1ps
module tb_fsync_divbank;
  localparam int NO = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0, sync_rate_8k = 1'b0, pll_locked = 1'b0;
  logic align_en = 1'b0, sync_qual = 1'b0, pbo_en = 1'b0;
  logic [NO*DW-1:0] div_ratio = '0;
  logic [2*NO-1:0]  freq_cls = '0;
  logic [NO-1:0]    clk_out;
  logic             cfg_err;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #2 clk = ~clk;

  fsync_divbank #(.NUM_OUT(NO), .DIV_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_rate_8k(sync_rate_8k),
    .pll_locked(pll_locked), .align_en(align_en), .sync_qual(sync_qual),
    .pbo_en(pbo_en), .div_ratio(div_ratio), .freq_cls(freq_cls),
    .clk_out(clk_out), .cfg_err(cfg_err)
  );

  // Behavioural reference: sync history queue and integer phases.
  bit hist[$];
  int ph[NO];
  bit exp_out[NO];
  bit exp_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {0, 0, 0};
      for (int i = 0; i < NO; i++) begin ph[i] = 65535; exp_out[i] = 0; end
      exp_err = 0;
    end else begin
      bit ev;
      ev = (hist[2] == 1) && (hist[1] == 0);
      hist.push_front(sync_in);
      void'(hist.pop_back());
      exp_err = pbo_en && align_en;
      for (int i = 0; i < NO; i++) begin
        int n, h, c;
        bit el;
        n = int'(div_ratio[i*DW +: DW]);
        if (n < 2) n = 2;
        h = n - n / 2;
        c = int'(freq_cls[2*i +: 2]);
        el = sync_rate_8k ? (c >= 2) : (c >= 1);
        if (ev && pll_locked && align_en && sync_qual && el) ph[i] = h;
        else if (ph[i] >= n - 1) ph[i] = 0;
        else ph[i] = ph[i] + 1;
        exp_out[i] = (ph[i] < h);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // Per-cycle comparison against the reference, tagged with the phase under test.
  always @(negedge clk) begin
    if (!finished) begin
      int a, e;
      a = 0; e = 0;
      for (int i = 0; i < NO; i++) begin a += int'(clk_out[i]) << i; e += int'(exp_out[i]) << i; end
      a += int'(cfg_err) << NO; e += int'(exp_err) << NO;
      chk(a == e, cur_req, a, e);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_out(input int i, input int r, input int c);
    div_ratio[i*DW +: DW] = DW'(r);
    freq_cls[2*i +: 2]   = 2'(c);
  endtask

  task automatic sync_fall_check(input string req, input bit [NO-1:0] low_mask);
    sync_in = 1'b1; tick(7);
    sync_in = 1'b0;            // first sampled low at next edge k
    tick(3);                   // now after edge k+2
    for (int i = 0; i < NO; i++)
      if (low_mask[i]) chk(clk_out[i] == 1'b0, req, int'(clk_out[i]), 0);
    tick(5);
  endtask

  initial begin
    set_out(0, 8, 0); set_out(1, 5, 1); set_out(2, 12, 2); set_out(3, 6, 3);
    cur_req = "R1";
    tick(4);
    chk(clk_out == '0, "R1", int'(clk_out), 0);
    chk(cfg_err == 1'b0, "R1", int'(cfg_err), 0);
    rst_n = 1'b1;
    tick(1);
    chk(clk_out == '1, "R2", int'(clk_out), 15); // first high phase after release

    cur_req = "R2"; tick(50);

    // R3 / R5: 2 kHz sync aligns classes 1..3
    cur_req = "R3"; pll_locked = 1; align_en = 1; sync_qual = 1;
    tick(3);
    sync_fall_check("R3", 4'b1110);
    tick(9);
    sync_fall_check("R3", 4'b1110);

    // R5: 4/8 kHz sync aligns only classes 2 and 3
    cur_req = "R5"; sync_rate_8k = 1;
    tick(7);
    sync_fall_check("R5", 4'b1100);
    set_out(1, 7, 1); tick(4);
    sync_fall_check("R5", 4'b1100);
    sync_rate_8k = 0;

    // R6: each gate dropped alone blocks realignment
    cur_req = "R6"; pll_locked = 0; tick(5); sync_fall_check("R6", 4'b0000);
    pll_locked = 1; align_en = 0;  tick(3); sync_fall_check("R6", 4'b0000);
    align_en = 1;  sync_qual = 0;  tick(6); sync_fall_check("R6", 4'b0000);
    sync_qual = 1;

    // R4: rising edges and steady levels leave phases alone
    cur_req = "R4";
    sync_in = 0; tick(11);
    sync_in = 1; tick(13);
    sync_in = 1; tick(20);
    sync_in = 0; tick(3);
    chk(clk_out[2] == 1'b0, "R4", int'(clk_out[2]), 0);
    sync_in = 0; tick(30);

    // R7: configuration conflict flag
    cur_req = "R7"; pbo_en = 1; tick(1);
    chk(cfg_err == 1'b1, "R7", int'(cfg_err), 1);
    align_en = 0; tick(1);
    chk(cfg_err == 1'b0, "R7", int'(cfg_err), 0);
    align_en = 1; tick(2); pbo_en = 0; tick(1);
    chk(cfg_err == 1'b0, "R7", int'(cfg_err), 0);

    // R8 / R2: ratio below two behaves as two, neighbours unaffected
    cur_req = "R8"; set_out(0, 1, 3); set_out(3, 0, 0); tick(20);
    sync_fall_check("R8", 4'b0111);
    set_out(2, 3, 2); tick(25);
    sync_fall_check("R8", 4'b0111);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule